// File: doc/BRIEF.md
# Lamp Inverter Fault Supervisor

This block supervises a lamp inverter controller in the digital domain. Comparator results from the analog front end arrive as single-bit flags, one per cycle: two overvoltage taps, a lamp-current detect and two battery-level thresholds. The block also takes a supply-good flag, an enable pin, a dimming-cycle start pulse and the burst-dimming chop signal. From these it drives the switching enable, a startup flag, the enable for the main driver and an 8-bit soft-start level.

After power-on reset, and again on every rising edge of the enable pin, the block enters a startup phase of fixed length. During that phase no fault check runs. After it, every dimming-cycle start pulse opens a blanking window and restarts the soft-start ramp from zero. The low-tap overvoltage check and the lamp-current check are masked while the window is open. The high-tap overvoltage check runs at all times once startup is over.

Any fault latches and stops switching until the next rising edge of the enable pin or a reset. The battery flags feed a hysteretic gate that can only switch off the main driver. Analog thresholds are modelled as clock counts: `STARTUP_CYCLES` (by default 1000 times `BLANK_CYCLES`), `BLANK_CYCLES` and `RAMP_TICK_CYCLES`.

Top module: `lampFaultSupervisor`

## Requirements
- R1: While reset is held and in the first cycle after it, startupFlag is 1, faultLatched is 0, softLevel is 0 and mainDriverEnable is 0.
- R2: startupFlag stays high for STARTUP_CYCLES clock edges after reset, then drops to 0. A rising edge of enablePin, sampled at a clock edge, raises it again and restarts the count.
- R3: While startupFlag is 1, none of ovpLow, ovpHigh or a missing currentDetect can set faultLatched.
- R4: Once startup is over, ovpHigh sampled high at a clock edge sets faultLatched, whether or not blanking is active.
- R5: A cycleStart pulse opens a blanking window that lasts BLANK_CYCLES clock edges. After startup, ovpLow sets faultLatched only when it is sampled high outside that window.
- R6: After startup and outside blanking, currentDetect sampled low on 4 consecutive clock edges sets faultLatched on the 4th edge. Fewer than 4 consecutive low samples set nothing.
- R7: faultLatched stays 1 until a rising edge of enablePin or a reset, and switchEnable is 0 while it is 1.
- R8: switchEnable is 1 exactly when supplyGood is 1, chopActive is 0 and faultLatched is 0. This is combinational from those inputs.
- R9: softLevel returns to 0 on the edge after cycleStart or an enablePin rising edge. It then rises by 1 every RAMP_TICK_CYCLES edges and saturates at 255.
- R10: During startup only, ovpHigh sampled high holds softLevel at 0. The ramp resumes its count once ovpHigh clears.
- R11: A battBelowLower sample turns the main gate off and a battAboveUpper sample turns it on; otherwise the gate holds. Lower wins if both are high. mainDriverEnable equals the gate AND switchEnable, and the battery flags never change switchEnable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, synchronous |
| supplyGood | input | 1 | Supply valid flag |
| enablePin | input | 1 | Chip enable; rising edge restarts startup and clears faults |
| cycleStart | input | 1 | One-cycle pulse at each dimming-cycle start |
| chopActive | input | 1 | Burst-dimming off phase |
| ovpLow | input | 1 | Low-tap overvoltage comparator flag |
| ovpHigh | input | 1 | High-tap overvoltage comparator flag |
| currentDetect | input | 1 | Lamp current above minimum |
| battAboveUpper | input | 1 | Battery above turn-on threshold |
| battBelowLower | input | 1 | Battery below turn-off threshold |
| switchEnable | output | 1 | Enable for all switching circuitry |
| startupFlag | output | 1 | High during the startup phase |
| mainDriverEnable | output | 1 | Enable for the battery-gated main driver |
| faultLatched | output | 1 | A fault has been latched |
| softLevel | output | 8 | Soft-start duty-limit ramp value |

## Verification
A wrong phase register shows up in the same cycle on startupFlag. Within one edge it also shows as a fault that is set or missing on faultLatched, and switchEnable drops with it. A lamp-watchdog counter off by one shifts the fault by a single cycle, so the bench compares faultLatched on every clock rather than at the end of a scenario. Ramp tick or clear errors show on softLevel at the next tick boundary. A battery gate that holds the wrong state shows on mainDriverEnable as soon as switchEnable is high.

// File: rtl/lfsPkg.sv
package lfsPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic startupRestart;
    logic startupCount;
    logic blankRestart;
    logic rampClear;
    logic watchClear;
    logic watchCount;
  } lfsStrobes_t;

  // status from datapath back to control
  typedef struct packed {
    logic startupDone;
    logic blankActive;
    logic missFull;
  } lfsStatus_t;

  localparam int unsigned LEVEL_W = 8;
  localparam int unsigned LAMP_WINDOW = 4;

endpackage

// File: rtl/lfsDatapath.sv
module lfsDatapath
  import lfsPkg::*;
#(
  parameter int unsigned STARTUP_CYCLES   = 8000,
  parameter int unsigned BLANK_CYCLES     = 8,
  parameter int unsigned RAMP_TICK_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lfsStrobes_t          stb,
  output lfsStatus_t           status,
  output logic [LEVEL_W-1:0]   rampLevel
);

  localparam int unsigned START_W = $clog2(STARTUP_CYCLES + 1);
  localparam int unsigned BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam int unsigned TICK_W  = $clog2(RAMP_TICK_CYCLES + 1);
  localparam int unsigned MISS_W  = $clog2(LAMP_WINDOW);
  localparam logic [START_W-1:0] START_LAST = START_W'(STARTUP_CYCLES - 1);
  localparam logic [BLANK_W-1:0] BLANK_END  = BLANK_W'(BLANK_CYCLES);
  localparam logic [TICK_W-1:0]  TICK_LAST  = TICK_W'(RAMP_TICK_CYCLES - 1);
  localparam logic [MISS_W-1:0]  MISS_LAST  = MISS_W'(LAMP_WINDOW - 1);
  localparam logic [LEVEL_W-1:0] LEVEL_MAX  = '1;

  logic [START_W-1:0] startCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic [TICK_W-1:0]  tickCnt;
  logic [MISS_W-1:0]  missCnt;

  // startup length counter
  always_ff @(posedge clk) begin
    if (!rstN || stb.startupRestart) begin
      startCnt <= '0;
    end else if (stb.startupCount && startCnt != START_LAST) begin
      startCnt <= startCnt + 1'b1;
    end
  end

  // blanking window counter, saturates at its end
  always_ff @(posedge clk) begin
    if (!rstN || stb.blankRestart) begin
      blankCnt <= '0;
    end else if (blankCnt != BLANK_END) begin
      blankCnt <= blankCnt + 1'b1;
    end
  end

  // soft-start ramp
  always_ff @(posedge clk) begin
    if (!rstN || stb.rampClear) begin
      tickCnt   <= '0;
      rampLevel <= '0;
    end else if (tickCnt == TICK_LAST) begin
      tickCnt <= '0;
      if (rampLevel != LEVEL_MAX) begin
        rampLevel <= rampLevel + 1'b1;
      end
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  // lamp-current miss counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN || stb.watchClear) begin
      missCnt <= '0;
    end else if (stb.watchCount && missCnt != MISS_LAST) begin
      missCnt <= missCnt + 1'b1;
    end
  end

  assign status.startupDone = (startCnt == START_LAST);
  assign status.blankActive = (blankCnt != BLANK_END);
  assign status.missFull    = (missCnt == MISS_LAST);

  AST_RAMP_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.rampClear |=> rampLevel == '0); // R9

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rampClear |=> (rampLevel == $past(rampLevel) || rampLevel == $past(rampLevel) + 1'b1)); // R9

  AST_BLANK_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    stb.blankRestart |=> status.blankActive); // R5

endmodule

// File: rtl/lfsControl.sv
module lfsControl
  import lfsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supplyGood,
  input  logic        enablePin,
  input  logic        cycleStart,
  input  logic        chopActive,
  input  logic        ovpLow,
  input  logic        ovpHigh,
  input  logic        currentDetect,
  input  logic        battAboveUpper,
  input  logic        battBelowLower,
  input  lfsStatus_t  status,
  output lfsStrobes_t stb,
  output logic        switchEnable,
  output logic        startupFlag,
  output logic        mainDriverEnable,
  output logic        faultLatched
);

  logic enPrev;
  logic inStartup;
  logic mainGate;
  logic enRise;
  logic checkEn;
  logic ovLowHit;
  logic ovHighHit;
  logic lampHit;

  assign enRise    = enablePin & ~enPrev;
  assign checkEn   = ~inStartup & ~status.blankActive;
  assign ovLowHit  = checkEn & ovpLow;
  assign ovHighHit = ~inStartup & ovpHigh;
  assign lampHit   = checkEn & ~currentDetect & status.missFull;

  always_comb begin
    stb.startupRestart = enRise;
    stb.startupCount   = inStartup;
    stb.blankRestart   = cycleStart;
    stb.rampClear      = enRise | cycleStart | (inStartup & ovpHigh);
    stb.watchClear     = ~checkEn | currentDetect;
    stb.watchCount     = checkEn & ~currentDetect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev <= 1'b0;
    end else begin
      enPrev <= enablePin;
    end
  end

  // startup phase
  always_ff @(posedge clk) begin
    if (!rstN || enRise) begin
      inStartup <= 1'b1;
    end else if (inStartup && status.startupDone) begin
      inStartup <= 1'b0;
    end
  end

  // fault latch; an enable rise clears it
  always_ff @(posedge clk) begin
    if (!rstN || enRise) begin
      faultLatched <= 1'b0;
    end else if (ovLowHit || ovHighHit || lampHit) begin
      faultLatched <= 1'b1;
    end
  end

  // battery hysteresis gate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainGate <= 1'b0;
    end else if (battBelowLower) begin
      mainGate <= 1'b0;
    end else if (battAboveUpper) begin
      mainGate <= 1'b1;
    end
  end

  assign switchEnable     = supplyGood & ~chopActive & ~faultLatched;
  assign startupFlag      = inStartup;
  assign mainDriverEnable = mainGate & switchEnable;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !enRise) |=> faultLatched); // R7

  AST_FAULT_STOPS_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> !switchEnable); // R7

  AST_STARTUP_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (inStartup && !faultLatched) |=> !faultLatched); // R3

  AST_BATT_LOW_OFF: assert property (@(posedge clk) disable iff (!rstN)
    battBelowLower |=> !mainDriverEnable); // R11

  AST_RISE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    enRise |=> startupFlag); // R2

endmodule

// File: rtl/lampFaultSupervisor.sv
module lampFaultSupervisor
  import lfsPkg::*;
#(
  parameter int unsigned BLANK_CYCLES     = 8,
  parameter int unsigned STARTUP_CYCLES   = 1000 * BLANK_CYCLES,
  parameter int unsigned RAMP_TICK_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       enablePin,
  input  logic       cycleStart,
  input  logic       chopActive,
  input  logic       ovpLow,
  input  logic       ovpHigh,
  input  logic       currentDetect,
  input  logic       battAboveUpper,
  input  logic       battBelowLower,
  output logic       switchEnable,
  output logic       startupFlag,
  output logic       mainDriverEnable,
  output logic       faultLatched,
  output logic [7:0] softLevel
);

  lfsStrobes_t stb;
  lfsStatus_t  status;
  logic [LEVEL_W-1:0] rampLevel;

  lfsControl u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .supplyGood       (supplyGood),
    .enablePin        (enablePin),
    .cycleStart       (cycleStart),
    .chopActive       (chopActive),
    .ovpLow           (ovpLow),
    .ovpHigh          (ovpHigh),
    .currentDetect    (currentDetect),
    .battAboveUpper   (battAboveUpper),
    .battBelowLower   (battBelowLower),
    .status           (status),
    .stb              (stb),
    .switchEnable     (switchEnable),
    .startupFlag      (startupFlag),
    .mainDriverEnable (mainDriverEnable),
    .faultLatched     (faultLatched)
  );

  lfsDatapath #(
    .STARTUP_CYCLES   (STARTUP_CYCLES),
    .BLANK_CYCLES     (BLANK_CYCLES),
    .RAMP_TICK_CYCLES (RAMP_TICK_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .status    (status),
    .rampLevel (rampLevel)
  );

  assign softLevel = rampLevel;

endmodule

// File: tb/sim_lampFaultSupervisor.sv
module sim_lampFaultSupervisor;

  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 6;
  localparam int STARTUP = 40;
  localparam int TICK = 2;

  logic clk = 0;
  logic rstN = 0;
  logic supplyGood = 1, enablePin = 1, cycleStart = 0, chopActive = 0;
  logic ovpLow = 0, ovpHigh = 0, currentDetect = 1;
  logic battAboveUpper = 0, battBelowLower = 0;
  logic switchEnable, startupFlag, mainDriverEnable, faultLatched;
  logic [7:0] softLevel;

  int checks = 0;
  int failures = 0;
  int cycleCount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lampFaultSupervisor #(
    .BLANK_CYCLES(BLANK), .STARTUP_CYCLES(STARTUP), .RAMP_TICK_CYCLES(TICK)
  ) u0 (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .enablePin(enablePin),
    .cycleStart(cycleStart), .chopActive(chopActive), .ovpLow(ovpLow),
    .ovpHigh(ovpHigh), .currentDetect(currentDetect),
    .battAboveUpper(battAboveUpper), .battBelowLower(battBelowLower),
    .switchEnable(switchEnable), .startupFlag(startupFlag),
    .mainDriverEnable(mainDriverEnable), .faultLatched(faultLatched),
    .softLevel(softLevel)
  );

  // behavioural reference state
  bit mStart, mEnPrev, mFault, mGate;
  int mStartAge, mSinceCycle, mTickAge, mLevel, mMissRun;

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycleCount, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (!rstN) begin
      mStart = 1; mEnPrev = 0; mFault = 0; mGate = 0;
      mStartAge = 0; mSinceCycle = 0; mTickAge = 0; mLevel = 0; mMissRun = 0;
    end else begin
      bit rise, checking, hit;
      rise = enablePin && !mEnPrev;
      checking = !mStart && (mSinceCycle >= BLANK);
      hit = (!mStart && ovpHigh) || (checking && ovpLow) ||
            (checking && !currentDetect && mMissRun + 1 >= 4);
      if (rise) mFault = 0; else if (hit) mFault = 1;
      if (!checking || currentDetect) mMissRun = 0; else mMissRun = mMissRun + 1;
      if (rise || cycleStart || (mStart && ovpHigh)) begin
        mLevel = 0; mTickAge = 0;
      end else begin
        mTickAge++;
        if (mTickAge == TICK) begin
          mTickAge = 0;
          if (mLevel < 255) mLevel++;
        end
      end
      if (rise) begin
        mStart = 1; mStartAge = 0;
      end else if (mStart) begin
        mStartAge++;
        if (mStartAge == STARTUP) mStart = 0;
      end
      if (cycleStart) mSinceCycle = 0; else mSinceCycle++;
      if (battBelowLower) mGate = 0; else if (battAboveUpper) mGate = 1;
      mEnPrev = enablePin;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit expSw;
      expSw = supplyGood && !chopActive && !mFault;
      check("R2", startupFlag, mStart);
      check("R7", faultLatched, mFault);
      check("R8", switchEnable, expSw);
      check("R11", mainDriverEnable, expSw && mGate);
      check("R9", softLevel, mLevel);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulseCycle();
    cycleStart = 1; step(1); cycleStart = 0;
  endtask

  task automatic reArm();
    enablePin = 0; step(2); enablePin = 1; step(STARTUP + 3);
  endtask

  initial begin
    #1;
    step(3);
    @(negedge clk);
    check("R1", startupFlag, 1); check("R1", faultLatched, 0);
    check("R1", softLevel, 0);   check("R1", mainDriverEnable, 0);
    @(posedge clk); #1;
    rstN = 1;
    step(1);
    @(negedge clk);
    check("R1", softLevel, 0); check("R1", startupFlag, 1);
    @(posedge clk); #1;

    // R3 / R10: faults ignored in startup, ramp held by high tap
    ovpLow = 1; currentDetect = 0; step(6);
    ovpHigh = 1; step(5);
    @(negedge clk); check("R10", softLevel, 0); check("R3", faultLatched, 0);
    @(posedge clk); #1;
    ovpHigh = 0; ovpLow = 0; currentDetect = 1; step(6);
    @(negedge clk); check("R10", softLevel, 3);
    @(posedge clk); #1;
    step(STARTUP);
    @(negedge clk); check("R2", startupFlag, 0); check("R3", faultLatched, 0);
    @(posedge clk); #1;

    // R5: low tap masked in blanking, fires after
    pulseCycle();
    ovpLow = 1; step(BLANK - 2);
    @(negedge clk); check("R5", faultLatched, 0);
    @(posedge clk); #1;
    step(4);
    @(negedge clk); check("R5", faultLatched, 1); check("R7", switchEnable, 0);
    @(posedge clk); #1;
    ovpLow = 0; step(5);
    @(negedge clk); check("R7", faultLatched, 1);
    @(posedge clk); #1;
    reArm();
    @(negedge clk); check("R7", faultLatched, 0); check("R2", startupFlag, 0);
    @(posedge clk); #1;

    // R4: high tap during blanking after startup
    pulseCycle();
    ovpHigh = 1; step(1); ovpHigh = 0;
    @(negedge clk); check("R4", faultLatched, 1);
    @(posedge clk); #1;
    reArm();

    // R6: lamp-current watchdog
    pulseCycle(); step(BLANK + 2);
    repeat (4) begin
      currentDetect = 0; step(3); currentDetect = 1; step(1);
    end
    @(negedge clk); check("R6", faultLatched, 0);
    @(posedge clk); #1;
    currentDetect = 0; step(3);
    @(negedge clk); check("R6", faultLatched, 0);
    @(posedge clk); #1;
    step(1);
    @(negedge clk); check("R6", faultLatched, 1);
    @(posedge clk); #1;
    currentDetect = 1;
    reArm();

    // R8 / R11: supply, chop, battery hysteresis
    battAboveUpper = 1; step(1); battAboveUpper = 0; step(2);
    @(negedge clk); check("R11", mainDriverEnable, 1);
    @(posedge clk); #1;
    supplyGood = 0; #1; check("R8", switchEnable, 0); step(2); supplyGood = 1;
    chopActive = 1; #1; check("R8", switchEnable, 0); check("R11", mainDriverEnable, 0);
    step(2); chopActive = 0;
    battBelowLower = 1; step(1); battBelowLower = 0; step(2);
    @(negedge clk); check("R11", mainDriverEnable, 0); check("R11", switchEnable, 1);
    @(posedge clk); #1;
    battAboveUpper = 1; battBelowLower = 1; step(1);
    battAboveUpper = 0; battBelowLower = 0; step(1);
    @(negedge clk); check("R11", mainDriverEnable, 0);
    @(posedge clk); #1;

    // R9: ramp saturation and clear
    pulseCycle(); step(600);
    @(negedge clk); check("R9", softLevel, 255);
    @(posedge clk); #1;
    pulseCycle();
    @(negedge clk); check("R9", softLevel, 0);
    @(posedge clk); #1;
    step(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule